// File: doc/BRIEF.md
# Byte-Wise Instruction Fetch Assembler

This block sits between a byte-wide memory read port and a datapath that consumes 16-bit instructions and 8-bit data operands. Each memory access delivers one byte, so an instruction period issues two instruction-byte reads followed by one data-byte read. The instruction address advances by one after each of the two instruction reads. Its least significant bit therefore alternates 0 then 1, and two consecutive bytes form one instruction.

Each accepted byte goes into one of three holding registers. The choice is made by a 2-bit route: a phase input (0 = instruction fetch, 1 = data fetch) and the address LSB. In the instruction phase, LSB 0 selects the upper instruction byte and LSB 1 selects the lower instruction byte. In the data phase the byte always goes to the data register, and the LSB has no effect.

The read side is a valid/ready stream. A byte is taken on a rising edge when `rd_valid` and `rd_ready` are both high. The block never applies back-pressure: `rd_ready` is high whenever reset is low. An upstream source may therefore drive one byte per cycle without stalling. The outputs are plain registered values, plus a one-cycle strobe that marks a freshly completed instruction.

Top module: `byte_fetch_assembler`

## Requirements
- R1: While `rst` is high at a rising edge, all three holding registers clear to zero. After that edge `instr_word` reads 0x0000, `data_byte` reads 0x00 and `instr_valid` reads 0.
- R2: An accepted byte with `phase_data`=0 and `addr_lsb`=0 is written to `instr_word[15:8]`. The lower instruction byte and `data_byte` keep their values.
- R3: An accepted byte with `phase_data`=0 and `addr_lsb`=1 is written to `instr_word[7:0]`. The upper instruction byte and `data_byte` keep their values.
- R4: An accepted byte with `phase_data`=1 is written to `data_byte` whatever the value of `addr_lsb`. `instr_word` keeps its value.
- R5: In a cycle where `rd_valid` is 0, no holding register changes, whatever the values of `rd_byte`, `phase_data` and `addr_lsb`.
- R6: `instr_valid` is 1 for exactly the one cycle that follows an accepted write to the lower instruction byte, and 0 in every other cycle.
- R7: `rd_ready` is 1 whenever `rst` is 0, and 0 while `rst` is 1. The block never back-pressures the read stream.
- R8: Two consecutive accepted instruction bytes (LSB 0, then LSB 1) assemble into `instr_word` = {first byte, second byte`}`. A data access that follows them leaves that word intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | A memory read byte is present |
| rd_ready | output | 1 | The block can accept a byte (high outside reset) |
| rd_byte | input | BYTE_W | Byte returned by memory |
| phase_data | input | 1 | 0 = instruction phase, 1 = data phase |
| addr_lsb | input | 1 | Least significant bit of the access address |
| instr_word | output | 2*BYTE_W | Assembled instruction, upper byte first |
| data_byte | output | BYTE_W | Latest data operand byte |
| instr_valid | output | 1 | One-cycle strobe after the lower instruction byte is written |

## Verification
The bench first uses directed sequences. A normal fetch stream runs upper byte, lower byte, data byte; this shows whether the two instruction bytes land in the correct halves of the word. Data accesses are then issued with both LSB values, which exposes any decoder that wrongly lets the LSB affect the data route. Idle cycles carry busy data and phase values, which separates a register that is gated by `rd_valid` from one that loads every cycle. After that, a long random stream mixes all route values with gaps in `rd_valid`. Every cycle is compared with a bench model, so that swapped, duplicated or missing write enables and a misplaced `instr_valid` pulse all show up.

// File: rtl/byte_fetch_pkg.sv
package byte_fetch_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_HI   = 0;
  localparam int SLOT_LO   = 1;
  localparam int SLOT_DATA = 2;

  typedef enum logic [1:0] {
    ROUTE_HI   = 2'd0,
    ROUTE_LO   = 2'd1,
    ROUTE_DATA = 2'd2,
    ROUTE_NONE = 2'd3
  } route_e;

  function automatic route_e pick_route(input logic take, input logic phase,
                                        input logic lsb);
    if (!take)      return ROUTE_NONE;
    else if (phase) return ROUTE_DATA;
    else if (lsb)   return ROUTE_LO;
    else            return ROUTE_HI;
  endfunction
endpackage

// File: rtl/byte_fetch_route.sv
module byte_fetch_route
  import byte_fetch_pkg::*;
(
  input  logic                 take,
  input  logic                 phase_data,
  input  logic                 addr_lsb,
  output logic [NUM_SLOTS-1:0] wr_en
);
  route_e route;

  always_comb begin
    route = pick_route(take, phase_data, addr_lsb);
    wr_en = '0;
    unique case (route)
      ROUTE_HI:   wr_en[SLOT_HI]   = 1'b1;
      ROUTE_LO:   wr_en[SLOT_LO]   = 1'b1;
      ROUTE_DATA: wr_en[SLOT_DATA] = 1'b1;
      default:    wr_en = '0;
    endcase
  end
endmodule

// File: rtl/byte_fetch_slot.sv
module byte_fetch_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  // R5: an unloaded slot holds its value
  p_slot_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/byte_fetch_assembler.sv
module byte_fetch_assembler
  import byte_fetch_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [BYTE_W-1:0]   rd_byte,
  input  logic                phase_data,
  input  logic                addr_lsb,
  output logic [2*BYTE_W-1:0] instr_word,
  output logic [BYTE_W-1:0]   data_byte,
  output logic                instr_valid
);
  localparam int INSTR_W = 2 * BYTE_W;

  logic                 take;
  logic [NUM_SLOTS-1:0] wr_en;
  logic [BYTE_W-1:0]    slot_q [NUM_SLOTS];

  assign rd_ready = !rst;
  assign take     = rd_valid && rd_ready;

  byte_fetch_route u_route (
    .take       (take),
    .phase_data (phase_data),
    .addr_lsb   (addr_lsb),
    .wr_en      (wr_en)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    byte_fetch_slot #(.WIDTH(BYTE_W)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .load (wr_en[s]),
      .din  (rd_byte),
      .q    (slot_q[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) instr_valid <= 1'b0;
    else     instr_valid <= wr_en[SLOT_LO];
  end

  assign instr_word = {slot_q[SLOT_HI], slot_q[SLOT_LO]};
  assign data_byte  = slot_q[SLOT_DATA];

  // R1: reset clears every output register
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (instr_word == '0 && data_byte == '0 && !instr_valid));

  // R2: instruction phase, LSB 0 -> upper byte
  p_hi_route_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !phase_data && !addr_lsb) |=>
      (instr_word[INSTR_W-1:BYTE_W] == $past(rd_byte)) && $stable(data_byte)
      && (instr_word[BYTE_W-1:0] == $past(instr_word[BYTE_W-1:0])));

  // R3: instruction phase, LSB 1 -> lower byte
  p_lo_route_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !phase_data && addr_lsb) |=>
      (instr_word[BYTE_W-1:0] == $past(rd_byte)) && $stable(data_byte)
      && (instr_word[INSTR_W-1:BYTE_W] == $past(instr_word[INSTR_W-1:BYTE_W])));

  // R4: data phase ignores LSB
  p_data_route_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && phase_data) |=>
      (data_byte == $past(rd_byte)) && $stable(instr_word));

  // R4: at most one slot written per edge
  p_one_slot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R5: idle cycles change nothing
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> $stable(instr_word) && $stable(data_byte));

  // R6: strobe only after a lower-byte write
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> $past(rd_valid && !phase_data && addr_lsb));

  // R7: never back-pressure outside reset
  p_ready_r7: assert property (@(posedge clk) !rst |-> rd_ready);
endmodule

// File: tb/byte_fetch_assembler_tb.sv
module byte_fetch_assembler_tb_top;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [BW-1:0] rd_byte = '0;
  logic          phase_data = 1'b0;
  logic          addr_lsb = 1'b0;
  logic [2*BW-1:0] instr_word;
  logic [BW-1:0] data_byte;
  logic          instr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [BW-1:0] m_hi = '0, m_lo = '0, m_data = '0;
  logic          m_valid = 1'b0;

  always #2 clk = ~clk;

  byte_fetch_assembler #(.BYTE_W(BW)) dut_i (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_byte(rd_byte), .phase_data(phase_data), .addr_lsb(addr_lsb),
    .instr_word(instr_word), .data_byte(data_byte), .instr_valid(instr_valid)
  );

  // 0 = upper, 1 = lower, 2 = data, 3 = nothing
  function automatic int exp_route(input logic v, input logic ph, input logic l);
    if (!v) return 3;
    if (ph) return 2;
    return l ? 1 : 0;
  endfunction

  function automatic string route_tag(input int r);
    case (r)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "instr_word", instr_word, {m_hi, m_lo});
    check(tag, "data_byte", data_byte, m_data);
    check("R6", "instr_valid", instr_valid, m_valid);
    check("R7", "rd_ready", rd_ready, 1);
  endtask

  task automatic access(input logic v, input logic ph, input logic l,
                        input logic [BW-1:0] b, output string tag);
    int r;
    @(negedge clk);
    rd_valid = v; phase_data = ph; addr_lsb = l; rd_byte = b;
    @(posedge clk);
    r = exp_route(v, ph, l);
    case (r)
      0: m_hi = b;
      1: m_lo = b;
      2: m_data = b;
      default: ;
    endcase
    m_valid = (r == 1);
    tag = route_tag(r);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    void'($urandom(32'h1234_5678));
    // R1 / R7: reset
    rd_valid = 1'b1; rd_byte = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check("R7", "rd_ready in reset", rd_ready, 0);
    check("R1", "instr_word", instr_word, 0);
    check("R1", "data_byte", data_byte, 0);
    check("R1", "instr_valid", instr_valid, 0);
    @(negedge clk);
    rst = 1'b0; rd_valid = 1'b0;
    #1;
    check("R7", "rd_ready after reset", rd_ready, 1);

    // R8: normal fetch sequence
    access(1, 0, 0, 8'hA5, tag); check_all("R2");
    check("R6", "no strobe after upper", instr_valid, 0);
    access(1, 0, 1, 8'h3C, tag); check_all("R3");
    check("R8", "assembled word", instr_word, 16'hA53C);
    check("R6", "strobe after lower", instr_valid, 1);
    access(1, 1, 0, 8'h77, tag); check_all("R4");
    check("R8", "word kept over data", instr_word, 16'hA53C);
    check("R6", "strobe one cycle", instr_valid, 0);
    // R4: LSB ignored in data phase
    access(1, 1, 1, 8'h81, tag); check_all("R4");
    check("R4", "data with lsb1", data_byte, 8'h81);
    check("R4", "instr untouched lsb1", instr_word, 16'hA53C);
    // R5: idle cycles with busy inputs
    access(0, 0, 0, 8'h11, tag); check_all("R5");
    access(0, 0, 1, 8'h22, tag); check_all("R5");
    access(0, 1, 1, 8'h33, tag); check_all("R5");
    check("R5", "idle instr", instr_word, 16'hA53C);
    check("R5", "idle data", data_byte, 8'h81);
    // R6: back-to-back lower writes
    access(1, 0, 1, 8'h01, tag); check_all("R3");
    access(1, 0, 1, 8'h02, tag); check_all("R3");
    check("R6", "strobe repeat", instr_valid, 1);

    // random stream
    for (int i = 0; i < 3000; i++) begin
      logic v, ph, l;
      logic [BW-1:0] b;
      v = ($urandom % 4) != 0; ph = $urandom % 2; l = $urandom % 2;
      b = BW'($urandom);
      access(v, ph, l, b, tag);
      check_all(tag);
    end

    // R1: mid-stream reset
    @(negedge clk); rst = 1'b1; rd_valid = 1'b1; phase_data = 1'b0; addr_lsb = 1'b1;
    @(posedge clk); #1;
    m_hi = '0; m_lo = '0; m_data = '0; m_valid = 1'b0;
    check("R1", "instr after reset", instr_word, 0);
    check("R1", "data after reset", data_byte, 0);
    check("R1", "valid after reset", instr_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule